// File: doc/BRIEF.md
# State Injection Path with Hold

This block sits on the next-state path of a small synchronous controller, between the combinational logic that computes the next state and the state register, and it contains that register. With every control line low it is transparent: the register loads exactly the next state the controller computed. Raising one or more control lines forces chosen bits of the next state high, low or to their complement, so that a test can load states the controller can never reach from reset by ordinary transitions. Which bits each control line touches is fixed at elaboration time by three mask parameters, one bit per (line, state bit) pair.

A hold input freezes the state register whatever the controller's inputs and the control lines do, so that a test can apply many input vectors from one loaded state without repeating the sequence that got there. The unmodified next-state lines are brought out as observation outputs, and the modified next state is also visible before the register. A synchronous active-high reset loads a parameterised reset state and wins over hold.

Top module: `state_inject_hold`

## Requirements
- R1: With all control lines 0, `inj_next` equals `next_in` bit for bit.
- R2: A bit whose set-mask entry is 1 for an active control line is forced to 1 before clearing and inversion; default set masks are line0 0000, line1 1010, line2 0000 (bit 3 on the left).
- R3: A bit whose clear-mask entry is 1 for an active control line is forced to 0 after setting; default clear masks are line0 0000, line1 0000, line2 0011.
- R4: A bit is inverted once for each active control line whose invert-mask entry is 1 (an even count leaves it unchanged); default invert masks are line0 0110, line1 0000, line2 1000, so line0 alone turns 0011 into 0101.
- R5: With several control lines active, their effects on a bit combine in the order set, then clear, then invert.
- R6: With reset and hold both low, `state_q` takes the value `inj_next` had before the clock edge, one cycle after it is presented.
- R7: With hold high and reset low, `state_q` keeps its value across the clock edge whatever `next_in` and `ctrl` are.
- R8: `obs_next` equals `next_in` whatever the control lines are.
- R9: With reset high at a clock edge, `state_q` becomes the reset state (default 0001) even when hold is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | CTRL_W (3) | Injection control lines, one per mask entry |
| hold | input | 1 | Freeze the state register |
| next_in | input | STATE_W (4) | Next state from the controller's combinational logic |
| obs_next | output | STATE_W (4) | Unmodified next state, for observation |
| inj_next | output | STATE_W (4) | Next state after set, clear and invert |
| state_q | output | STATE_W (4) | Present state held in the register |

## Verification
The injected next state and the observation copy are combinational, so they are due in the same cycle as the stimulus; the bench drives on the falling edge and checks them a nanosecond later, before any clock edge. The register result is due one rising edge later, so the bench checks `state_q` on the following falling edge. Under hold, `state_q` is compared against the value captured before hold rose, once per cycle while the inputs change randomly, and the reset checks likewise look one edge after reset is sampled.

// File: rtl/sinj_pkg.sv
package sinj_pkg;

    typedef enum logic [1:0] {
        REG_LOAD  = 2'd0,
        REG_HOLD  = 2'd1,
        REG_RESET = 2'd2
    } reg_mode_e;

    // Reset outranks hold, hold outranks load.
    function automatic reg_mode_e pick_mode(input logic rst, input logic hold);
        if (rst)
            return REG_RESET;
        else if (hold)
            return REG_HOLD;
        else
            return REG_LOAD;
    endfunction

endpackage

// File: rtl/sinj_mask_fold.sv
module sinj_mask_fold #(
    parameter int unsigned W       = 4,
    parameter int unsigned N       = 3,
    parameter bit          USE_XOR = 1'b0,
    parameter logic [N-1:0][W-1:0] MASK = '0
) (
    input  logic [N-1:0] ctrl,
    output logic [W-1:0] hit
);

    // One reduction per state bit over the control lines that touch it.
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [N-1:0] sel;
        for (genvar l = 0; l < N; l++) begin : g_line
            assign sel[l] = ctrl[l] & MASK[l][b];
        end
        if (USE_XOR) begin : g_par
            assign hit[b] = ^sel;
        end else begin : g_any
            assign hit[b] = |sel;
        end
    end

endmodule

// File: rtl/sinj_apply.sv
module sinj_apply #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] nxt,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    input  logic [W-1:0] inv_v,
    output logic [W-1:0] out
);

    logic [W-1:0] after_set;
    logic [W-1:0] after_clr;

    always_comb begin
        after_set = nxt | set_v;
        after_clr = after_set & ~clr_v;
        out       = after_clr ^ inv_v;
    end

endmodule

// File: rtl/sinj_state_reg.sv
module sinj_state_reg
    import sinj_pkg::*;
#(
    parameter int unsigned W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    reg_mode_e mode;

    always_comb mode = pick_mode(rst, hold);

    always_ff @(posedge clk) begin
        unique case (mode)
            REG_RESET: q <= RST_VAL;
            REG_HOLD:  q <= q;
            default:   q <= d;
        endcase
    end

endmodule

// File: rtl/state_inject_hold.sv
module state_inject_hold #(
    parameter int unsigned STATE_W = 4,
    parameter int unsigned CTRL_W  = 3,
    parameter logic [CTRL_W-1:0][STATE_W-1:0] SET_MASK = {4'b0000, 4'b1010, 4'b0000},
    parameter logic [CTRL_W-1:0][STATE_W-1:0] CLR_MASK = {4'b0011, 4'b0000, 4'b0000},
    parameter logic [CTRL_W-1:0][STATE_W-1:0] INV_MASK = {4'b1000, 4'b0000, 4'b0110},
    parameter logic [STATE_W-1:0] RST_STATE = 4'b0001
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CTRL_W-1:0]  ctrl,
    input  logic               hold,
    input  logic [STATE_W-1:0] next_in,
    output logic [STATE_W-1:0] obs_next,
    output logic [STATE_W-1:0] inj_next,
    output logic [STATE_W-1:0] state_q
);

    logic [STATE_W-1:0] set_v;
    logic [STATE_W-1:0] clr_v;
    logic [STATE_W-1:0] inv_v;

    sinj_mask_fold #(.W(STATE_W), .N(CTRL_W), .USE_XOR(1'b0), .MASK(SET_MASK))
        u_set (.ctrl(ctrl), .hit(set_v));

    sinj_mask_fold #(.W(STATE_W), .N(CTRL_W), .USE_XOR(1'b0), .MASK(CLR_MASK))
        u_clr (.ctrl(ctrl), .hit(clr_v));

    sinj_mask_fold #(.W(STATE_W), .N(CTRL_W), .USE_XOR(1'b1), .MASK(INV_MASK))
        u_inv (.ctrl(ctrl), .hit(inv_v));

    sinj_apply #(.W(STATE_W)) u_apply (
        .nxt  (next_in),
        .set_v(set_v),
        .clr_v(clr_v),
        .inv_v(inv_v),
        .out  (inj_next)
    );

    sinj_state_reg #(.W(STATE_W), .RST_VAL(RST_STATE)) u_reg (
        .clk (clk),
        .rst (rst),
        .hold(hold),
        .d   (inj_next),
        .q   (state_q)
    );

    assign obs_next = next_in;

endmodule

// File: rtl/sinj_chk.sv
module sinj_chk #(
    parameter int unsigned STATE_W = 4,
    parameter int unsigned CTRL_W  = 3,
    parameter logic [STATE_W-1:0] RST_STATE = '0
) (
    input logic               clk,
    input logic               rst,
    input logic [CTRL_W-1:0]  ctrl,
    input logic               hold,
    input logic [STATE_W-1:0] next_in,
    input logic [STATE_W-1:0] inj_next,
    input logic [STATE_W-1:0] state_q
);

    // R1
    transparent_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl == '0) |-> (inj_next == next_in));

    // R6
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold) |=> (state_q == $past(inj_next)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hold) |=> $stable(state_q));

    // R9
    reset_chk: assert property (@(posedge clk)
        rst |=> (state_q == RST_STATE));

endmodule

bind state_inject_hold sinj_chk #(
    .STATE_W  (STATE_W),
    .CTRL_W   (CTRL_W),
    .RST_STATE(RST_STATE)
) u_sinj_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .hold    (hold),
    .next_in (next_in),
    .inj_next(inj_next),
    .state_q (state_q)
);

// File: tb/tb_state_inject_hold.sv
module tb_state_inject_hold;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ctrl = '0;
    logic       hold = 1'b0;
    logic [3:0] next_in = '0;
    logic [3:0] obs_next;
    logic [3:0] inj_next;
    logic [3:0] state_q;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    state_inject_hold dut (
        .clk     (clk),
        .rst     (rst),
        .ctrl    (ctrl),
        .hold    (hold),
        .next_in (next_in),
        .obs_next(obs_next),
        .inj_next(inj_next),
        .state_q (state_q)
    );

    // {ctrl[2:0], next_in[3:0], expected inj_next[3:0]}
    localparam logic [10:0] VEC [12] = '{
        {3'b000, 4'b0011, 4'b0011},   // R1
        {3'b000, 4'b1010, 4'b1010},   // R1
        {3'b001, 4'b0011, 4'b0101},   // R4 worked example
        {3'b001, 4'b1111, 4'b1001},   // R4
        {3'b010, 4'b0000, 4'b1010},   // R2
        {3'b010, 4'b0101, 4'b1111},   // R2
        {3'b100, 4'b1111, 4'b0100},   // R3 then R4
        {3'b100, 4'b0000, 4'b1000},   // R3 then R4
        {3'b011, 4'b0011, 4'b1101},   // R2 then R4
        {3'b111, 4'b0101, 4'b0010},   // R5 all lines
        {3'b110, 4'b0001, 4'b0000},   // R5 set, clear, invert cancel
        {3'b101, 4'b1100, 4'b0010}    // R4 parity of two lines
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] frozen;
        repeat (2) @(negedge clk);
        check("R9 reset state", state_q, 4'b0001);
        rst = 1'b0;

        foreach (VEC[i]) begin
            @(negedge clk);
            ctrl    = VEC[i][10:8];
            next_in = VEC[i][7:4];
            #1;
            check($sformatf("R1-5 vec%0d inj", i), inj_next, VEC[i][3:0]);
            check("R8 obs", obs_next, VEC[i][7:4]);
            @(negedge clk);
            check("R6 load", state_q, VEC[i][3:0]);
        end

        // Hold: load 0101 via injection, then freeze while inputs wander.
        @(negedge clk);
        ctrl = 3'b001; next_in = 4'b0011;
        @(negedge clk);
        check("R6 load before hold", state_q, 4'b0101);
        frozen = state_q;
        hold = 1'b1;
        for (int k = 0; k < 20; k++) begin
            ctrl    = 3'($urandom);
            next_in = 4'($urandom);
            @(negedge clk);
            check("R7 hold", state_q, frozen);
        end
        ctrl = 3'b000; next_in = 4'b1110;
        #1;
        check("R8 obs under hold", obs_next, 4'b1110);
        check("R1 inj under hold", inj_next, 4'b1110);

        // Reset wins over hold.
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset over hold", state_q, 4'b0001);
        rst = 1'b0;
        @(negedge clk);
        check("R7 hold after reset", state_q, 4'b0001);
        hold = 1'b0;
        @(negedge clk);
        check("R6 release hold", state_q, 4'b1110);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule